// File: doc/BRIEF.md
# Step-Down Regulator Protection Sequencer

This block decides, cycle by cycle, whether the pass transistor of a fixed-frequency step-down regulator may conduct. It divides the system clock into switching periods and marks the last cycle of each period with a one-cycle tick. Within each period the switch follows the PWM comparator result. Two protection paths can override it.

The first path handles over-current. A cycle-by-cycle over-current flag cuts the switch at once. It also starts a blanking interval of a fixed number of clock cycles, during which the switch stays off. A flag that arrives while blanking is already running is ignored, so the interval is never stretched. Repeated faults therefore give intermittent switching, with one full off interval after each event.

The second path is a hysteretic thermal latch fed by an unsigned junction-temperature code. While the latch is set, the switch is held off and the downstream linear regulator is disabled. An over-current event alone leaves that regulator running. After reset the switch stays off until the first period boundary has passed.

Top module: `buck_guard_seq`

## Requirements
- R1: While reset is asserted, `sw_en_o` is 0, `ldo_en_o` is 1, and `prd_tick_o`, `oc_hold_o` and `hot_o` are 0.
- R2: `prd_tick_o` is high for exactly one clock cycle in every `PERIOD_CYC` cycles. It first rises after the (`PERIOD_CYC`-1)-th rising edge following reset release.
- R3: After reset, `sw_en_o` stays 0 whatever the PWM input does, until the rising edge at which `prd_tick_o` is high has passed.
- R4: Once armed, with no fault present, `sw_en_o` equals `pwm_cmp_i` in the same cycle.
- R5: When `oc_cmp_i` is 1, `sw_en_o` is 0 in that same cycle. If no hold is running, `oc_hold_o` is then high for exactly `OC_OFF_CYC` cycles starting at the next edge, and `sw_en_o` stays 0 throughout.
- R6: An `oc_cmp_i` pulse while `oc_hold_o` is high neither extends nor restarts the hold.
- R7: An over-current flag that arrives after a hold has ended starts a new full hold, and switching resumes after it ends.
- R8: One cycle after `temp_code_i` is at or above `TSD_TRIP`, `hot_o` is 1. While `hot_o` is 1, both `sw_en_o` and `ldo_en_o` are 0.
- R9: `hot_o` stays 1 while `temp_code_i` is above `TSD_CLEAR`. It returns to 0 one cycle after the code is at or below `TSD_CLEAR`, which re-enables the regulator and switching.
- R10: An over-current hold does not change `ldo_en_o`.
- R11: While cold, a code strictly between `TSD_CLEAR` and `TSD_TRIP` does not set `hot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_cmp_i | input | 1 | PWM comparator result, 1 = conduct |
| oc_cmp_i | input | 1 | Cycle-by-cycle over-current comparator flag |
| temp_code_i | input | TEMP_W | Unsigned junction-temperature code |
| sw_en_o | output | 1 | Pass-transistor enable |
| ldo_en_o | output | 1 | Linear regulator enable |
| prd_tick_o | output | 1 | Last cycle of each switching period |
| oc_hold_o | output | 1 | Over-current blanking in progress |
| hot_o | output | 1 | Thermal shutdown latched |

## Verification
The switch enable is combinational from the PWM and over-current inputs, so it is checked one time step after the inputs change at the falling edge, in the same cycle. The hold flag and the thermal flag are registered. They are checked at the next falling edge after the stimulus, and the hold is counted falling edge by falling edge until it drops, which must occur after exactly `OC_OFF_CYC` edges. The period tick and the arming of the switch are checked at every falling edge after reset release, against the count of rising edges that have passed.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  // Fault view used by the enable gate.
  typedef struct packed {
    logic blank;
    logic hot;
  } bgs_fault_t;

  // Next phase of the switching-period counter.
  function automatic int unsigned bgs_step_phase(int unsigned phase, int unsigned period);
    if (phase + 1 >= period) return 0;
    return phase + 1;
  endfunction

  // Next value of the over-current hold counter. A trigger only loads an idle counter.
  function automatic int unsigned bgs_step_hold(int unsigned left, logic trig, int unsigned span);
    if (left != 0) return left - 1;
    if (trig) return span;
    return 0;
  endfunction

  // Next thermal state with separate trip and clear levels.
  function automatic logic bgs_step_hot(logic hot, int unsigned temp,
                                        int unsigned trip_lvl, int unsigned clr_lvl);
    if (hot) return (temp > clr_lvl);
    return (temp >= trip_lvl);
  endfunction

endpackage

// File: rtl/bgs_timebase.sv
module bgs_timebase
  import bgs_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 755
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  generate
    if (PERIOD_CYC <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= PW'(bgs_step_phase(32'(phase_q), PERIOD_CYC));
      end

      assign tick_o = (32'(phase_q) == PERIOD_CYC - 1);

      // R2: the tick lasts a single cycle
      p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      // R2: the phase never leaves its range
      p_phase_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(phase_q) < PERIOD_CYC);
    end
  endgenerate

endmodule

// File: rtl/bgs_oc_blank.sv
module bgs_oc_blank
  import bgs_pkg::*;
#(
  parameter int unsigned OFF_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  output logic hold_o,
  output logic event_o
);

  localparam int unsigned HW = $clog2(OFF_CYC + 1);

  logic [HW-1:0] left_q;

  assign hold_o  = (left_q != '0);
  assign event_o = oc_i && !hold_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= HW'(bgs_step_hold(32'(left_q), oc_i, OFF_CYC));
  end

  // R5: an accepted event loads the full interval
  p_event_loads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> (32'(left_q) == OFF_CYC));
  // R6: a running hold only counts down, never reloads
  p_no_extend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> (left_q == $past(left_q) - HW'(1)));
  // R7: a flag after the hold has ended starts a new hold
  p_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && oc_i) |=> hold_o);

endmodule

// File: rtl/bgs_thermal.sv
module bgs_thermal
  import bgs_pkg::*;
#(
  parameter int unsigned TEMP_W    = 9,
  parameter int unsigned TSD_TRIP  = 200,
  parameter int unsigned TSD_CLEAR = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);

  logic        hot_q;
  int unsigned temp_u;

  assign temp_u = 32'(temp_i);
  assign hot_o  = hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hot_q <= 1'b0;
    else         hot_q <= bgs_step_hot(hot_q, temp_u, TSD_TRIP, TSD_CLEAR);
  end

  p_trip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hot_q && temp_u >= TSD_TRIP) |=> hot_q);
  p_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_q && temp_u > TSD_CLEAR) |=> hot_q);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_q && temp_u <= TSD_CLEAR) |=> !hot_q);
  p_band_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hot_q && temp_u < TSD_TRIP) |=> !hot_q);

endmodule

// File: rtl/buck_guard_seq.sv
module buck_guard_seq
  import bgs_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 755,
  parameter int unsigned OC_OFF_CYC = 5000,
  parameter int unsigned TEMP_W     = 9,
  parameter int unsigned TSD_TRIP   = 200,
  parameter int unsigned TSD_CLEAR  = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_cmp_i,
  input  logic              oc_cmp_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic              sw_en_o,
  output logic              ldo_en_o,
  output logic              prd_tick_o,
  output logic              oc_hold_o,
  output logic              hot_o
);

  logic       prd_tick;
  logic       oc_hold;
  logic       oc_event;
  logic       hot;
  logic       armed_q;
  bgs_fault_t flt;

  bgs_timebase #(.PERIOD_CYC(PERIOD_CYC)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (prd_tick)
  );

  bgs_oc_blank #(.OFF_CYC(OC_OFF_CYC)) u_oc_blank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oc_i    (oc_cmp_i),
    .hold_o  (oc_hold),
    .event_o (oc_event)
  );

  bgs_thermal #(
    .TEMP_W    (TEMP_W),
    .TSD_TRIP  (TSD_TRIP),
    .TSD_CLEAR (TSD_CLEAR)
  ) u_thermal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .temp_i (temp_code_i),
    .hot_o  (hot)
  );

  // The switch is held off from reset until the first period boundary.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_q | prd_tick;
  end

  assign flt.blank = oc_hold | oc_cmp_i;
  assign flt.hot   = hot;

  assign sw_en_o    = armed_q & pwm_cmp_i & ~flt.blank & ~flt.hot;
  assign ldo_en_o   = ~flt.hot;
  assign prd_tick_o = prd_tick;
  assign oc_hold_o  = oc_hold;
  assign hot_o      = hot;

  p_arm_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !sw_en_o);
  p_arm_at_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(prd_tick));
  p_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !oc_cmp_i && !oc_hold && !hot) |-> (sw_en_o == pwm_cmp_i));
  p_evt_cut_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_event || oc_hold) |-> !sw_en_o);
  p_hot_cut_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot |-> (!sw_en_o && !ldo_en_o));

endmodule

// File: tb/test_buck_guard_seq.sv
module test_buck_guard_seq;

  localparam int unsigned PRD  = 20;
  localparam int unsigned OFF  = 12;
  localparam int unsigned TW   = 8;
  localparam int unsigned TRIP = 200;
  localparam int unsigned CLR  = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm = 1'b0;
  logic          oc = 1'b0;
  logic [TW-1:0] temp = 8'd25;
  logic          sw_en, ldo_en, tick, hold, hot;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  buck_guard_seq #(
    .PERIOD_CYC (PRD),
    .OC_OFF_CYC (OFF),
    .TEMP_W     (TW),
    .TSD_TRIP   (TRIP),
    .TSD_CLEAR  (CLR)
  ) i_buck_guard_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwm_cmp_i   (pwm),
    .oc_cmp_i    (oc),
    .temp_code_i (temp),
    .sw_en_o     (sw_en),
    .ldo_en_o    (ldo_en),
    .prd_tick_o  (tick),
    .oc_hold_o   (hold),
    .hot_o       (hot)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // R1: outputs while in reset
  task automatic t_reset_state();
    pwm = 1'b1; oc = 1'b0; temp = 8'd25; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "sw_en", sw_en, 1'b0);
    chk("R1", "ldo_en", ldo_en, 1'b1);
    chk("R1", "tick", tick, 1'b0);
    chk("R1", "hold", hold, 1'b0);
    chk("R1", "hot", hot, 1'b0);
  endtask

  // R2, R3: tick cadence and arming after release
  task automatic t_startup();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 2 * PRD + 1; i++) begin
      @(negedge clk);
      #1;
      chk("R2", "tick", tick, (i == PRD - 1) || (i == 2 * PRD - 1));
      chk("R3", "sw_en", sw_en, (i >= PRD) ? 1'b1 : 1'b0);
    end
  endtask

  // R4: switch follows PWM with no fault
  task automatic t_follow_pwm();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pwm = logic'(i[0] ^ i[2] ^ i[3]);
      #1;
      chk("R4", "sw_en", sw_en, pwm);
    end
    pwm = 1'b1;
  endtask

  // R5, R6, R10: one event, a second flag inside the hold is ignored
  task automatic t_oc_interval();
    @(negedge clk);
    oc = 1'b1;
    #1;
    chk("R5", "sw_en same cycle", sw_en, 1'b0);
    chk("R5", "hold not yet", hold, 1'b0);
    for (int j = 1; j <= OFF + 1; j++) begin
      @(negedge clk);
      oc = (j == 3) ? 1'b1 : 1'b0;
      #1;
      chk("R6", "hold", hold, (j <= OFF) ? 1'b1 : 1'b0);
      chk("R5", "sw_en", sw_en, (j <= OFF || oc) ? 1'b0 : 1'b1);
      chk("R10", "ldo_en", ldo_en, 1'b1);
    end
  endtask

  // R7: back-to-back events give intermittent switching
  task automatic t_oc_repeat();
    for (int n = 0; n < 2; n++) begin
      int len;
      @(negedge clk);
      oc = 1'b1;
      #1;
      chk("R7", "sw_en on event", sw_en, 1'b0);
      @(negedge clk);
      oc = 1'b0;
      #1;
      chk("R7", "hold starts", hold, 1'b1);
      len = 1;
      while (hold && len < 100) begin
        @(negedge clk);
        #1;
        if (hold) len++;
      end
      vectors++;
      if (len != int'(OFF)) begin
        miscompares++;
        $display("FAIL R7 hold length: actual %0d expected %0d", len, OFF);
      end
      chk("R7", "sw_en resumes", sw_en, 1'b1);
    end
  endtask

  // R11: codes between the two levels do not trip a cold latch
  task automatic t_thermal_band();
    @(negedge clk);
    temp = 8'(TRIP - 1);
    repeat (3) begin
      @(negedge clk);
      #1;
      chk("R11", "hot", hot, 1'b0);
      chk("R11", "ldo_en", ldo_en, 1'b1);
    end
    temp = 8'(CLR + 1);
    @(negedge clk);
    #1;
    chk("R11", "hot mid", hot, 1'b0);
  endtask

  // R8, R9: trip, hold through the band, release at the clear level
  task automatic t_thermal_trip_release();
    @(negedge clk);
    temp = 8'(TRIP);
    #1;
    chk("R8", "hot not yet", hot, 1'b0);
    chk("R8", "sw_en before", sw_en, 1'b1);
    @(negedge clk);
    #1;
    chk("R8", "hot", hot, 1'b1);
    chk("R8", "sw_en", sw_en, 1'b0);
    chk("R8", "ldo_en", ldo_en, 1'b0);
    temp = 8'(CLR + 1);
    repeat (2) begin
      @(negedge clk);
      #1;
      chk("R9", "hot kept", hot, 1'b1);
      chk("R9", "ldo_en kept off", ldo_en, 1'b0);
    end
    temp = 8'(CLR);
    #1;
    chk("R9", "hot before edge", hot, 1'b1);
    @(negedge clk);
    #1;
    chk("R9", "hot cleared", hot, 1'b0);
    chk("R9", "ldo_en back", ldo_en, 1'b1);
    chk("R9", "sw_en back", sw_en, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_startup();
    t_follow_pwm();
    t_oc_interval();
    t_oc_repeat();
    t_thermal_band();
    t_thermal_trip_release();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule